// File: doc/BRIEF.md
# Dual-Cascade DMA Channel Register File

This block holds the software-visible register set of a pair of four-channel DMA controllers that share an 8-bit I/O port. The first controller serves channels 0 to 3 and moves bytes. The second serves channels 4 to 7 and moves 16-bit words, and its channel 4 is the input that controller one cascades into. Every register port is eight bits wide. A 16-bit address or count therefore takes two accesses to the same port, and a per-controller byte pointer selects the low or high byte.

For each channel the block keeps a base and a current address, a base and a current count, a page byte, a mask bit, two mode flags and a terminal-count flag. It presents the live address, count and the resulting 24-bit physical address to the transfer engine. A one-cycle transfer tick per channel advances that channel's address and count. Bus arbitration and memory cycles belong to a separate engine.

Top module: `dma_chan_rf`

## Requirements
- R1: 16-bit address and count registers are accessed low byte first through one 8-bit port. Each controller has its own byte pointer. The pointer flips on every read or write of any address or count port of that controller (0 = low byte, 1 = high byte). A write loads the selected byte into both the base and the current register.
- R2: Any write to a controller's clear-pointer port returns that controller's byte pointer to the low byte. A write to its master-clear port does the same, masks all four of that controller's channels and clears their terminal-count flags. The other controller is not affected.
- R3: Port map for controller one: channel n address at 2n, count at 2n+1, status 0x08, single mask 0x0A, mode 0x0B, clear-pointer 0x0C, master clear 0x0D. Controller two uses even offsets from 0xC0: channel 4+n address at 0xC0+4n, count at 0xC2+4n, status 0xD0, mask 0xD4, mode 0xD6, clear-pointer 0xD8, master clear 0xDA. The page byte of channel c is at 0x80+c.
- R4: A single-mask write uses data bits [1:0] to select the channel within the controller. Bit 2 = 1 masks that channel and bit 2 = 0 unmasks it.
- R5: A mode write uses data bits [1:0] to select the channel. Bit 4 = 1 enables auto-initialise. Bits [7:6] = 11 select cascade, and in cascade mode the channel ignores transfer ticks. Any other value of bits [7:6] lets ticks act.
- R6: A tick on an unmasked channel that is not in cascade mode increments the current address and decrements the current count, both modulo 65536. The page byte never changes when the address wraps. Ticks on masked channels have no effect.
- R7: When a tick takes the current count from 0x0000, the channel's terminal-count flag is set. A write to that channel's count port or a master clear clears the flag. A read of a status port returns that controller's four flags in bits [3:0], lowest channel in bit 0, with bits [7:4] zero.
- R8: With auto-initialise on, the tick that sets the terminal-count flag reloads the current address and count from their base values instead of stepping them.
- R9: The physical address output is {page, address} for channels 0-3. For channels 4-7 it is {page[7:1], address, 0}: page bit 0 is ignored and a page spans 128K.
- R10: After reset all channels are masked, both byte pointers select the low byte, and all addresses, counts, pages, mode flags and terminal-count flags are zero.
- R11: A tick that arrives in the same cycle as an address or count write to the same channel is dropped. The written byte lands and nothing is stepped.
- R12: Reads of address and count ports return the byte of the current (live) value selected by the pointer. A page port returns its stored byte. Unmapped ports and write-only ports read 0x00, and `io_rdata` is 0x00 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Register write strobe, one cycle per access |
| io_rd | input | 1 | Register read strobe, one cycle per access; ignored while io_wr is high |
| io_addr | input | 8 | Port offset |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid combinationally during io_rd |
| xfer_tick | input | 8 | Per-channel transfer-complete pulse |
| cur_addr_o | output | 128 | Current address of each channel, channel c at bits [16c+15:16c] |
| cur_count_o | output | 128 | Current count of each channel, same packing |
| phys_addr_o | output | 192 | Physical address of each channel, channel c at bits [24c+23:24c] |
| mask_o | output | 8 | Mask bit per channel |
| tc_o | output | 8 | Terminal-count flag per channel |

## Verification
Two situations are the hardest to reach from the ports. The first is the count underflow with auto-initialise, where one tick must reload the base values rather than wrap. The second is a tick landing in the very cycle of a count write. The stimulus programs a word channel with a count of two, unmasks it and holds its tick for exactly three cycles. For the collision it drives a tick and a count write on the same falling edge. The byte-pointer history is pinned before each check by a clear-pointer write, so the expected low/high placement follows from the access order alone.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

  localparam int NUM_CH     = 8;
  localparam int CH_PER_CTL = 4;
  localparam int WORD_W     = 16;
  localparam int PAGE_W     = 8;
  localparam int PHYS_W     = PAGE_W + WORD_W;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ADDR,
    SEL_COUNT,
    SEL_STATUS,
    SEL_MASK,
    SEL_MODE,
    SEL_CLRFF,
    SEL_MCLR,
    SEL_PAGE
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic       ctl;
    logic [2:0] chan;
  } dec_t;

  // Port decode: controller two uses doubled (even) offsets from 0xC0.
  function automatic dec_t decode_port(input logic [7:0] a);
    dec_t       d;
    logic       hit;
    logic [3:0] off;
    d.sel  = SEL_NONE;
    d.ctl  = 1'b0;
    d.chan = 3'd0;
    hit    = 1'b0;
    off    = 4'd0;
    if (a[7:4] == 4'h0) begin
      hit   = 1'b1;
      off   = a[3:0];
      d.ctl = 1'b0;
    end else if (a[7:5] == 3'b110 && !a[0]) begin
      hit   = 1'b1;
      off   = a[4:1];
      d.ctl = 1'b1;
    end
    if (a[7:3] == 5'b10000) begin
      d.sel  = SEL_PAGE;
      d.chan = a[2:0];
      d.ctl  = a[2];
    end else if (hit) begin
      if (!off[3]) begin
        d.sel  = off[0] ? SEL_COUNT : SEL_ADDR;
        d.chan = {d.ctl, off[2:1]};
      end else begin
        case (off[2:0])
          3'd0:    d.sel = SEL_STATUS;
          3'd2:    d.sel = SEL_MASK;
          3'd3:    d.sel = SEL_MODE;
          3'd4:    d.sel = SEL_CLRFF;
          3'd5:    d.sel = SEL_MCLR;
          default: d.sel = SEL_NONE;
        endcase
      end
    end
    return d;
  endfunction

  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] old,
                                                 input logic hi, input logic [7:0] b);
    return hi ? {b, old[7:0]} : {old[15:8], b};
  endfunction

  function automatic logic [7:0] get_byte(input logic [WORD_W-1:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(input logic is_word,
                                                input logic [PAGE_W-1:0] pg,
                                                input logic [WORD_W-1:0] a);
    return is_word ? {pg[PAGE_W-1:1], a, 1'b0} : {pg, a};
  endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_rf_pkg::*;
(
  input  logic [7:0] io_addr,
  output dec_t       dec
);
  assign dec = decode_port(io_addr);
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi <= 1'b0;
    else if (clear) hi <= 1'b0;
    else if (step)  hi <= ~hi;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_rf_pkg::*;
#(
  parameter bit IS_WORD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              hi_sel,
  input  logic [7:0]        wdata,
  input  logic              wr_page,
  input  logic              wr_mode,
  input  logic              set_mask,
  input  logic              clr_mask,
  input  logic              mclr,
  input  logic              tick,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_cnt,
  output logic [PAGE_W-1:0] page,
  output logic [PHYS_W-1:0] phys,
  output logic              masked,
  output logic              tc,
  output logic              tick_eff,
  output logic              tc_evt,
  output logic              reload_evt
);
  logic [WORD_W-1:0] base_addr, base_cnt;
  logic              autoinit, cascade;

  assign tick_eff   = tick & ~masked & ~cascade & ~wr_addr & ~wr_cnt;
  assign tc_evt     = tick_eff & (cur_cnt == '0);
  assign reload_evt = tc_evt & autoinit;
  assign phys       = phys_of(IS_WORD, page, cur_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      page      <= '0;
      autoinit  <= 1'b0;
      cascade   <= 1'b0;
      masked    <= 1'b1;
      tc        <= 1'b0;
    end else begin
      if (wr_addr) begin
        base_addr <= put_byte(base_addr, hi_sel, wdata);
        cur_addr  <= put_byte(cur_addr, hi_sel, wdata);
      end
      if (wr_cnt) begin
        base_cnt <= put_byte(base_cnt, hi_sel, wdata);
        cur_cnt  <= put_byte(cur_cnt, hi_sel, wdata);
      end
      if (tick_eff) begin
        if (reload_evt) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
        end
      end
      if (wr_page) page <= wdata;
      if (wr_mode) begin
        autoinit <= wdata[4];
        cascade  <= &wdata[7:6];
      end
      if (mclr)          masked <= 1'b1;
      else if (set_mask) masked <= 1'b1;
      else if (clr_mask) masked <= 1'b0;
      if (mclr || wr_cnt) tc <= 1'b0;
      else if (tc_evt)    tc <= 1'b1;
    end
  end
endmodule

// File: rtl/dma_chan_rf.sv
module dma_chan_rf
  import dma_rf_pkg::*;
#(
  parameter int N_CH  = NUM_CH,
  parameter int PER_C = CH_PER_CTL
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic [7:0]               io_addr,
  input  logic [7:0]               io_wdata,
  output logic [7:0]               io_rdata,
  input  logic [N_CH-1:0]          xfer_tick,
  output logic [N_CH*WORD_W-1:0]   cur_addr_o,
  output logic [N_CH*WORD_W-1:0]   cur_count_o,
  output logic [N_CH*PHYS_W-1:0]   phys_addr_o,
  output logic [N_CH-1:0]          mask_o,
  output logic [N_CH-1:0]          tc_o
);
  localparam int N_CTL = N_CH / PER_C;

  dec_t dec;
  logic rd_en;

  logic [N_CTL-1:0] ptr_hi, clr_ff_evt, mclr_evt, ptr_step_evt;
  logic [N_CH-1:0]  mask_set_evt, tick_eff, tc_evt, reload_evt;

  logic [WORD_W-1:0] a_cur [N_CH];
  logic [WORD_W-1:0] c_cur [N_CH];
  logic [PAGE_W-1:0] pg    [N_CH];

  assign rd_en = io_rd & ~io_wr;

  dma_port_decode dec_i (.io_addr(io_addr), .dec(dec));

  for (genvar c = 0; c < N_CTL; c++) begin : g_ctl
    assign clr_ff_evt[c]   = io_wr & (dec.ctl == 1'(c)) &
                             ((dec.sel == SEL_CLRFF) | (dec.sel == SEL_MCLR));
    assign mclr_evt[c]     = io_wr & (dec.ctl == 1'(c)) & (dec.sel == SEL_MCLR);
    assign ptr_step_evt[c] = (io_wr | rd_en) & (dec.ctl == 1'(c)) &
                             ((dec.sel == SEL_ADDR) | (dec.sel == SEL_COUNT));
    dma_byte_ptr ptr_i (
      .clk(clk), .rst_n(rst_n),
      .clear(clr_ff_evt[c]), .step(ptr_step_evt[c]), .hi(ptr_hi[c])
    );
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam int         CTL = g / PER_C;
    localparam logic [1:0] SUB = 2'(g % PER_C);
    logic own_ctl, own_sub, hit_ch;
    assign own_ctl = (dec.ctl == 1'(CTL));
    assign own_sub = own_ctl & (io_wdata[1:0] == SUB);
    assign hit_ch  = (dec.chan == 3'(g));
    assign mask_set_evt[g] = io_wr & (dec.sel == SEL_MASK) & own_sub & io_wdata[2];

    dma_chan_regs #(.IS_WORD(CTL != 0)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_addr   (io_wr & (dec.sel == SEL_ADDR) & hit_ch),
      .wr_cnt    (io_wr & (dec.sel == SEL_COUNT) & hit_ch),
      .hi_sel    (ptr_hi[CTL]),
      .wdata     (io_wdata),
      .wr_page   (io_wr & (dec.sel == SEL_PAGE) & hit_ch),
      .wr_mode   (io_wr & (dec.sel == SEL_MODE) & own_sub),
      .set_mask  (mask_set_evt[g]),
      .clr_mask  (io_wr & (dec.sel == SEL_MASK) & own_sub & ~io_wdata[2]),
      .mclr      (mclr_evt[CTL]),
      .tick      (xfer_tick[g]),
      .cur_addr  (a_cur[g]),
      .cur_cnt   (c_cur[g]),
      .page      (pg[g]),
      .phys      (phys_addr_o[g*PHYS_W +: PHYS_W]),
      .masked    (mask_o[g]),
      .tc        (tc_o[g]),
      .tick_eff  (tick_eff[g]),
      .tc_evt    (tc_evt[g]),
      .reload_evt(reload_evt[g])
    );
    assign cur_addr_o[g*WORD_W +: WORD_W]  = a_cur[g];
    assign cur_count_o[g*WORD_W +: WORD_W] = c_cur[g];
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (dec.sel)
      SEL_ADDR:   rd_mux = get_byte(a_cur[dec.chan], ptr_hi[dec.ctl]);
      SEL_COUNT:  rd_mux = get_byte(c_cur[dec.chan], ptr_hi[dec.ctl]);
      SEL_STATUS: rd_mux = {4'b0000, dec.ctl ? tc_o[7:4] : tc_o[3:0]};
      SEL_PAGE:   rd_mux = pg[dec.chan];
      default:    rd_mux = 8'h00;
    endcase
  end
  assign io_rdata = rd_en ? rd_mux : 8'h00;

endmodule

// File: rtl/dma_rf_chk.sv
module dma_rf_chk
  import dma_rf_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 ptr_hi,
  input logic [1:0]                 clr_ff_evt,
  input logic [1:0]                 mclr_evt,
  input logic [1:0]                 ptr_step_evt,
  input logic [NUM_CH-1:0]          mask_set_evt,
  input logic [NUM_CH-1:0]          tick_eff,
  input logic [NUM_CH-1:0]          tc_evt,
  input logic [NUM_CH-1:0]          reload_evt,
  input logic [NUM_CH-1:0]          mask_o,
  input logic [NUM_CH-1:0]          tc_o,
  input logic [NUM_CH*WORD_W-1:0]   cur_count_o
);
  // R1
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ptr_step_evt) |=> ((ptr_hi ^ $past(ptr_hi)) == $past(ptr_step_evt)));

  // R2
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_ff_evt) |=> ((ptr_hi & $past(clr_ff_evt)) == 2'b00));

  // R2
  mclr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_evt[0] |=> (&mask_o[3:0]));

  // R2
  mclr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_evt[1] |=> (&mask_o[7:4]));

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_set_evt) |=> ((mask_o & $past(mask_set_evt)) == $past(mask_set_evt)));

  // R7
  tc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_evt) |=> ((tc_o & $past(tc_evt)) == $past(tc_evt)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_eff[i] && !reload_evt[i]) |=>
        (cur_count_o[i*WORD_W +: WORD_W] == $past(cur_count_o[i*WORD_W +: WORD_W]) - 16'd1));
  end
endmodule

bind dma_chan_rf dma_rf_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ptr_hi(ptr_hi), .clr_ff_evt(clr_ff_evt),
  .mclr_evt(mclr_evt), .ptr_step_evt(ptr_step_evt), .mask_set_evt(mask_set_evt),
  .tick_eff(tick_eff), .tc_evt(tc_evt), .reload_evt(reload_evt),
  .mask_o(mask_o), .tc_o(tc_o), .cur_count_o(cur_count_o)
);

// File: tb/dma_chan_rf_tb_top.sv
module dma_chan_rf_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]   io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0]   io_rdata;
  logic [7:0]   xfer_tick = 8'h00;
  logic [127:0] cur_addr_o, cur_count_o;
  logic [191:0] phys_addr_o;
  logic [7:0]   mask_o, tc_o;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  logic [15:0] ex_a [8];
  logic [15:0] ex_c [8];
  logic [7:0]  ex_p [8];

  always #2 clk = ~clk;

  dma_chan_rf dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .xfer_tick(xfer_tick),
    .cur_addr_o(cur_addr_o), .cur_count_o(cur_count_o), .phys_addr_o(phys_addr_o),
    .mask_o(mask_o), .tc_o(tc_o)
  );

  function automatic logic [7:0] p_addr(int ch);  return (ch < 4) ? 8'(2*ch)   : 8'(8'hC0 + 4*(ch-4)); endfunction
  function automatic logic [7:0] p_cnt(int ch);   return (ch < 4) ? 8'(2*ch+1) : 8'(8'hC2 + 4*(ch-4)); endfunction
  function automatic logic [7:0] p_clr(int ch);   return (ch < 4) ? 8'h0C : 8'hD8; endfunction
  function automatic logic [7:0] p_mask(int ch);  return (ch < 4) ? 8'h0A : 8'hD4; endfunction
  function automatic logic [7:0] p_mode(int ch);  return (ch < 4) ? 8'h0B : 8'hD6; endfunction
  function automatic logic [7:0] p_page(int ch);  return 8'(8'h80 + ch); endfunction

  function automatic logic [23:0] want_phys(int ch, logic [7:0] p, logic [15:0] a);
    int v;
    if (ch < 4) v = int'(p) * 65536 + int'(a);
    else        v = (int'(p) / 2) * 131072 + int'(a) * 2;
    return 24'(v);
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic tick(input int ch, input int n);
    @(negedge clk);
    xfer_tick[ch] = 1'b1;
    repeat (n) @(negedge clk);
    xfer_tick[ch] = 1'b0;
  endtask

  function automatic logic [15:0] ca(int ch); return cur_addr_o[ch*16 +: 16]; endfunction
  function automatic logic [15:0] cc(int ch); return cur_count_o[ch*16 +: 16]; endfunction
  function automatic logic [23:0] ph(int ch); return phys_addr_o[ch*24 +: 24]; endfunction

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] b0, b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 mask", 32'(mask_o), 32'hFF);
    chk("R10 tc", 32'(tc_o), 32'h0);
    chk("R10 counts", 32'(cur_count_o[31:0]), 32'h0);
    chk("R10 addr", 32'(cur_addr_o[127:96]), 32'h0);

    // R1 R3 R9 R12 sweep over all eight channels
    for (int ch = 0; ch < 8; ch++) begin
      ex_a[ch] = 16'((ch * 8191 + 16'h1234) & 16'hFFFF);
      ex_c[ch] = 16'((ch * 4099 + 16'h0042) & 16'hFFFF);
      ex_p[ch] = 8'((ch * 37 + 3) & 8'hFF);
      wr(p_clr(ch), 8'h00);
      wr(p_addr(ch), ex_a[ch][7:0]);
      wr(p_addr(ch), ex_a[ch][15:8]);
      wr(p_cnt(ch), ex_c[ch][7:0]);
      wr(p_cnt(ch), ex_c[ch][15:8]);
      wr(p_page(ch), ex_p[ch]);
      chk($sformatf("R1 R3 addr ch%0d", ch), 32'(ca(ch)), 32'(ex_a[ch]));
      chk($sformatf("R1 R3 count ch%0d", ch), 32'(cc(ch)), 32'(ex_c[ch]));
      chk($sformatf("R9 phys ch%0d", ch), 32'(ph(ch)), 32'(want_phys(ch, ex_p[ch], ex_a[ch])));
      rd(p_addr(ch), b0);
      rd(p_addr(ch), b1);
      chk($sformatf("R12 addr readback ch%0d", ch), 32'({b1, b0}), 32'(ex_a[ch]));
      rd(p_page(ch), b0);
      chk($sformatf("R12 page readback ch%0d", ch), 32'(b0), 32'(ex_p[ch]));
    end

    // R2 clear-pointer returns to low byte
    wr(8'h0C, 8'h00);
    wr(8'h00, 8'hAA);
    wr(8'h0C, 8'h00);
    wr(8'h00, 8'h55);
    chk("R2 clear pointer low", 32'(ca(0)), 32'({ex_a[0][15:8], 8'h55}));
    wr(8'h00, 8'h66);
    ex_a[0] = 16'h6655;
    chk("R1 next byte high", 32'(ca(0)), 32'(ex_a[0]));

    // R6 R7 wrap and terminal count on byte channel 1
    wr(8'h0C, 8'h00);
    wr(8'h02, 8'hFE); wr(8'h02, 8'hFF);
    wr(8'h03, 8'h03); wr(8'h03, 8'h00);
    wr(8'h81, 8'h12);
    tick(1, 3);
    chk("R6 masked ticks ignored", 32'(cc(1)), 32'h0003);
    wr(8'h0A, 8'h01);
    chk("R4 unmask ch1", 32'(mask_o[1]), 32'h0);
    tick(1, 5);
    chk("R6 addr wraps", 32'(ca(1)), 32'h0003);
    chk("R6 count steps down", 32'(cc(1)), 32'hFFFE);
    chk("R6 page unchanged", 32'(ph(1)), 32'h120003);
    chk("R7 tc set", 32'(tc_o[1]), 32'h1);
    rd(8'h08, b0);
    chk("R7 status ctl1", 32'(b0), 32'h02);
    wr(8'h03, 8'h10);
    chk("R7 count write clears tc", 32'(tc_o[1]), 32'h0);
    chk("R1 count lo byte", 32'(cc(1)), 32'hFF10);
    wr(8'h0A, 8'h05);
    chk("R4 mask ch1", 32'(mask_o[1]), 32'h1);
    tick(1, 2);
    chk("R6 masked ch1 idle", 32'(cc(1)), 32'hFF10);

    // R8 auto-initialise on word channel 6
    wr(8'hD8, 8'h00);
    wr(8'hD6, 8'h5A);
    wr(8'hC8, 8'h00); wr(8'hC8, 8'h01);
    wr(8'hCA, 8'h02); wr(8'hCA, 8'h00);
    wr(8'hD4, 8'h02);
    tick(6, 3);
    chk("R8 reload addr", 32'(ca(6)), 32'h0100);
    chk("R8 reload count", 32'(cc(6)), 32'h0002);
    chk("R7 tc ch6", 32'(tc_o[6]), 32'h1);
    tick(6, 1);
    chk("R8 resumes addr", 32'(ca(6)), 32'h0101);
    chk("R8 resumes count", 32'(cc(6)), 32'h0001);
    chk("R9 word phys ch6", 32'(ph(6)), 32'(want_phys(6, ex_p[6], 16'h0101)));
    rd(8'hD0, b0);
    chk("R7 status ctl2", 32'(b0), 32'h04);

    // R5 cascade mode on channel 4
    wr(8'hD6, 8'hC0);
    wr(8'hD4, 8'h00);
    tick(4, 4);
    chk("R5 cascade ignores tick", 32'(cc(4)), 32'(ex_c[4]));
    wr(8'hD6, 8'h44);
    tick(4, 1);
    ex_a[4] = ex_a[4] + 16'd1;
    chk("R5 normal mode steps", 32'(cc(4)), 32'(ex_c[4] - 16'd1));
    chk("R6 addr ch4 steps", 32'(ca(4)), 32'(ex_a[4]));

    // R11 tick and count write in the same cycle on channel 2
    wr(8'h0A, 8'h02);
    wr(8'h0C, 8'h00);
    @(negedge clk);
    io_addr = 8'h05; io_wdata = 8'h77; io_wr = 1'b1; xfer_tick[2] = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; xfer_tick[2] = 1'b0;
    chk("R11 collision count", 32'(cc(2)), 32'({ex_c[2][15:8], 8'h77}));
    chk("R11 collision addr", 32'(ca(2)), 32'(ex_a[2]));
    tick(2, 1);
    chk("R6 ch2 after collision", 32'(cc(2)), 32'({ex_c[2][15:8], 8'h76}));

    // R2 master clear of controller two
    wr(8'hDA, 8'h00);
    chk("R2 mclr masks ctl2", 32'(mask_o[7:4]), 32'hF);
    chk("R2 mclr clears tc", 32'(tc_o[6]), 32'h0);
    chk("R2 ctl1 untouched", 32'(mask_o[2]), 32'h0);
    wr(8'hC0, 8'h11);
    chk("R2 mclr pointer low", 32'(ca(4)), 32'({ex_a[4][15:8], 8'h11}));

    // R12 live count readback and unmapped read
    wr(8'hD8, 8'h00);
    rd(8'hCA, b0);
    rd(8'hCA, b1);
    chk("R12 live count", 32'({b1, b0}), 32'h0001);
    rd(8'h40, b0);
    chk("R12 unmapped reads zero", 32'(b0), 32'h00);
    rd(8'h0D, b0);
    chk("R12 write-only reads zero", 32'(b0), 32'h00);

    report();
  end
endmodule